// File: doc/BRIEF.md
# Receive Sampling Delay Tuning Sweep Engine

This block finds a good receive sampling delay for a high-speed memory-card bus. After a start request it steps a tap value upward through a fixed range. At each tap it loads the value into the delay line through an update request. It issues that request twice, waiting each time for the delay hardware to acknowledge it. It then asks an external agent to run one tuning-block transfer and records whether the transfer passed. It keeps the longest run of consecutive passing taps, and at the end it programs the tap at the centre of that run.

The engine runs only in the two high-speed timing modes that need tuning. In any other mode a start completes at once and the delay is left as it was. The sweep stops short of the top of the tap field because the upper tap codes wrap back to zero on the delay line. If a delay update is never acknowledged, the tap counts as failing and no transfer is run for it. If no tap passes at all, an error flag is raised and no value is programmed.

The finite-state machine has seven states. IDLE waits for start. UPD holds the update request. GAP drops the request for one cycle between the two issues. TEST holds the transfer request. EVAL folds the result into the run tracker and steps the tap. PICK chooses the centre or flags the error. DONE raises the completion pulse. The transitions are as follows. IDLE goes to UPD on start in a tuning mode, and to DONE on start in any other mode. UPD goes to GAP after the first acknowledge. After the second acknowledge it goes to TEST, or to DONE when it is applying the final value. On timeout UPD goes to EVAL, or to DONE during the final apply. GAP goes back to UPD. TEST goes to EVAL when the transfer reports back. EVAL goes to UPD for the next tap, or to PICK after tap 39. PICK goes to UPD to apply the chosen value, or to DONE when nothing passed. DONE goes to IDLE.

Top module: `tune_sweep_engine`

## Requirements
- R1: A start with `mode_i` equal to 3 or 5 runs the sweep. Any other mode code completes with a one-cycle `done_o` on the cycle after start, with no update or test request, `tap_o` unchanged and `err_o` low.
- R2: The sweep visits taps 0 to 39 in ascending order. `tap_o` never shows a value above 39 while an update request is high.
- R3: Each tap is applied by two separate update requests. Each request stays high until a one-cycle `upd_ack_i`, then drops for at least one cycle. The test request rises only on the cycle after the second acknowledge.
- R4: An update request that gets no acknowledge within 16 cycles is dropped. Its tap counts as failing and gets no test request.
- R5: A passing tap lengthens the current run and a failing tap clears it. A run replaces the best run only when it is strictly longer, so the earliest of equal runs wins.
- R6: The chosen tap is the last tap of the best run minus half the run length, rounded down. It is applied with two update requests and stays on `tap_o` afterwards.
- R7: If no tap passes, `err_o` rises together with `done_o` and no final update is issued.
- R8: `done_o` is high for exactly one cycle per accepted start. `err_o` stays high until the next accepted start clears it.
- R9: If the final value's update times out, `err_o` is raised at completion.
- R10: `tap_o` stays stable while the update request is high, and the update and test requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| mode_i | input | 3 | Bus timing mode code; 3 and 5 enable the sweep |
| upd_req_o | output | 1 | Delay update request, held until acknowledged or timed out |
| upd_ack_i | input | 1 | One-cycle pulse: update applied |
| tap_o | output | 6 | Delay tap value |
| test_req_o | output | 1 | Tuning transfer request, held until reported |
| test_done_i | input | 1 | One-cycle pulse: transfer finished |
| test_pass_i | input | 1 | Transfer result, valid with `test_done_i` |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | No usable tap found, held until next start |

## Verification
The assertions check the handshake rules on every cycle. They cover the tap held during an update, the tap range, the test request following an acknowledge, the one-cycle completion pulse, the error rising only at completion and clearing only on start, and the run length never exceeding the best. Other properties can only be shown by the bench's scenarios comparing the final tap and error against a reference sweep. These are whether the chosen tap is the right centre, whether ties go to the earliest window, whether a silent delay line costs exactly sixteen cycles, and whether the total number of update and test requests is right.

// File: rtl/tse_pkg.sv
package tse_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UPD,
        ST_GAP,
        ST_TEST,
        ST_EVAL,
        ST_PICK,
        ST_DONE
    } sweep_state_e;

    localparam logic [2:0] MODE_TUNE_A = 3'd3;
    localparam logic [2:0] MODE_TUNE_B = 3'd5;
endpackage

// File: rtl/tse_upd_timer.sv
module tse_upd_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i)
            cnt_q <= '0;
        else if (!expired_o)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = run_i && (cnt_q == CW'(LIMIT - 1));

    // R4
    expire_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |-> $past(run_i));
endmodule

// File: rtl/tse_window.sv
module tse_window #(
    parameter int TAP_W = 6,
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             step_i,
    input  logic             pass_i,
    input  logic [TAP_W-1:0] idx_i,
    output logic [LEN_W-1:0] best_len_o,
    output logic [TAP_W-1:0] pick_o
);
    logic [LEN_W-1:0] run_q;
    logic [LEN_W-1:0] best_q;
    logic [TAP_W-1:0] end_q;
    logic [LEN_W-1:0] run_inc;
    logic [LEN_W-1:0] centre;

    assign run_inc = run_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            best_q <= '0;
            end_q  <= '0;
        end else if (clr_i) begin
            run_q  <= '0;
            best_q <= '0;
            end_q  <= '0;
        end else if (step_i) begin
            if (pass_i) begin
                run_q <= run_inc;
                if (run_inc > best_q) begin
                    best_q <= run_inc;
                    end_q  <= idx_i;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    assign centre     = LEN_W'(end_q) - (best_q >> 1);
    assign pick_o     = centre[TAP_W-1:0];
    assign best_len_o = best_q;

    // R5
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= best_q);
    // R5
    best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> best_q >= $past(best_q));
endmodule

// File: rtl/tune_sweep_engine.sv
module tune_sweep_engine #(
    parameter int TAP_W       = 6,
    parameter int TAP_COUNT   = 40,
    parameter int UPD_TIMEOUT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       mode_i,
    output logic             upd_req_o,
    input  logic             upd_ack_i,
    output logic [TAP_W-1:0] tap_o,
    output logic             test_req_o,
    input  logic             test_done_i,
    input  logic             test_pass_i,
    output logic             done_o,
    output logic             err_o
);
    import tse_pkg::*;

    localparam int LEN_W = TAP_W + 1;
    localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(TAP_COUNT - 1);

    sweep_state_e state_q, state_d;

    logic [TAP_W-1:0] tap_q;
    logic [TAP_W-1:0] idx_q;
    logic             second_q;
    logic             final_q;
    logic             pass_q;
    logic             err_q;

    logic             sweep_mode;
    logic             expired;
    logic             accept;
    logic [LEN_W-1:0] best_len;
    logic [TAP_W-1:0] pick;

    assign sweep_mode = (mode_i == MODE_TUNE_A) || (mode_i == MODE_TUNE_B);
    assign accept     = (state_q == ST_IDLE) && start_i;

    tse_upd_timer #(.LIMIT(UPD_TIMEOUT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     ((state_q == ST_UPD) && !upd_ack_i),
        .expired_o (expired)
    );

    tse_window #(.TAP_W(TAP_W), .LEN_W(LEN_W)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (accept),
        .step_i     (state_q == ST_EVAL),
        .pass_i     (pass_q),
        .idx_i      (idx_q),
        .best_len_o (best_len),
        .pick_o     (pick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = sweep_mode ? ST_UPD : ST_DONE;
            ST_UPD: begin
                if (upd_ack_i) begin
                    if (!second_q)    state_d = ST_GAP;
                    else if (final_q) state_d = ST_DONE;
                    else              state_d = ST_TEST;
                end else if (expired) begin
                    state_d = final_q ? ST_DONE : ST_EVAL;
                end
            end
            ST_GAP:  state_d = ST_UPD;
            ST_TEST: if (test_done_i) state_d = ST_EVAL;
            ST_EVAL: state_d = (idx_q == LAST_TAP) ? ST_PICK : ST_UPD;
            ST_PICK: state_d = (best_len == '0) ? ST_DONE : ST_UPD;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_q    <= '0;
            idx_q    <= '0;
            second_q <= 1'b0;
            final_q  <= 1'b0;
            pass_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        err_q <= 1'b0;
                        if (sweep_mode) begin
                            tap_q    <= '0;
                            idx_q    <= '0;
                            second_q <= 1'b0;
                            final_q  <= 1'b0;
                        end
                    end
                end
                ST_UPD: begin
                    if (upd_ack_i) begin
                        second_q <= !second_q;
                    end else if (expired) begin
                        second_q <= 1'b0;
                        pass_q   <= 1'b0;
                        if (final_q) err_q <= 1'b1;
                    end
                end
                ST_TEST: if (test_done_i) pass_q <= test_pass_i;
                ST_EVAL: begin
                    if (idx_q != LAST_TAP) begin
                        idx_q <= idx_q + 1'b1;
                        tap_q <= idx_q + 1'b1;
                    end
                end
                ST_PICK: begin
                    if (best_len == '0) begin
                        err_q <= 1'b1;
                    end else begin
                        tap_q   <= pick;
                        final_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        upd_req_o  = 1'b0;
        test_req_o = 1'b0;
        done_o     = 1'b0;
        unique case (state_q)
            ST_UPD:  upd_req_o  = 1'b1;
            ST_TEST: test_req_o = 1'b1;
            ST_DONE: done_o     = 1'b1;
            default: ;
        endcase
    end

    assign tap_o = tap_q;
    assign err_o = err_q;

    // R10
    tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req_o && $past(upd_req_o) |-> $stable(tap_o));
    // R10
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_req_o && test_req_o));
    // R3
    test_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_req_o) |-> $past(upd_ack_i));
    // R2
    tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req_o |-> (tap_o <= LAST_TAP));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);
    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_o) |-> $past(start_i));
endmodule

// File: tb/test_tune_sweep_engine.sv
module test_tune_sweep_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] mode = 3'd3;
    logic       upd_req;
    logic       upd_ack = 1'b0;
    logic [5:0] tap;
    logic       test_req;
    logic       test_done = 1'b0;
    logic       test_pass = 1'b0;
    logic       done;
    logic       err;

    int checks = 0;
    int errors = 0;

    bit [39:0] mask;
    int  stuck = -1;
    bit  stuck_final = 1'b0;
    int  rises = 0;
    int  tests = 0;
    int  max_len = 0;

    always #2.5 clk = !clk;

    tune_sweep_engine i_tune_sweep_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .mode_i      (mode),
        .upd_req_o   (upd_req),
        .upd_ack_i   (upd_ack),
        .tap_o       (tap),
        .test_req_o  (test_req),
        .test_done_i (test_done),
        .test_pass_i (test_pass),
        .done_o      (done),
        .err_o       (err)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit [39:0] win(input int lo, input int hi);
        bit [39:0] m = '0;
        for (int i = lo; i <= hi; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic void model(input bit [39:0] m, input int stk, input bit stkf,
                                  output int ctr, output bit e, output int nr, output int nt);
        int run = 0;
        int best = 0;
        int endi = 0;
        nr = 0;
        nt = 0;
        for (int i = 0; i < 40; i++) begin
            bit p;
            if (i == stk) begin
                nr += 1;
                p = 1'b0;
            end else begin
                nr += 2;
                nt++;
                p = m[i];
            end
            if (p) begin
                run++;
                if (run > best) begin
                    best = run;
                    endi = i;
                end
            end else begin
                run = 0;
            end
        end
        if (best == 0) begin
            e = 1'b1;
            ctr = 0;
        end else begin
            ctr = endi - best / 2;
            if (stkf) begin
                e = 1'b1;
                nr += 1;
            end else begin
                e = 1'b0;
                nr += 2;
            end
        end
    endfunction

    // Responder: delay line and tuning transfer agent, driven on falling edges
    initial begin
        int  wcnt = 0;
        int  tcnt = 0;
        int  adly = 2;
        int  tdly = 2;
        int  len = 0;
        bit  prev = 1'b0;
        forever begin
            @(negedge clk);
            upd_ack = 1'b0;
            test_done = 1'b0;
            if (upd_req && !prev) rises++;
            if (upd_req) len++;
            else begin
                if (len > max_len) max_len = len;
                len = 0;
            end
            prev = upd_req;
            if (upd_req) begin
                wcnt++;
                if (wcnt >= adly && int'(tap) != stuck && !(stuck_final && tests == 40)) begin
                    upd_ack = 1'b1;
                    wcnt = 0;
                    adly = 1 + int'($urandom % 4);
                end
            end else begin
                wcnt = 0;
            end
            if (test_req) begin
                tcnt++;
                if (tcnt >= tdly) begin
                    test_done = 1'b1;
                    test_pass = mask[tap];
                    tests++;
                    tcnt = 0;
                    tdly = 1 + int'($urandom % 4);
                end
            end else begin
                tcnt = 0;
            end
        end
    end

    task automatic run_sweep(input bit [39:0] m, input int stk, input bit stkf,
                             input logic [2:0] md, input string tag);
        int cyc = 0;
        int ctr;
        bit e;
        int nr;
        int nt;
        logic [5:0] tap_before;
        bit sweep;
        sweep = (md == 3'd3) || (md == 3'd5);
        @(negedge clk);
        mask = m;
        stuck = stk;
        stuck_final = stkf;
        mode = md;
        rises = 0;
        tests = 0;
        max_len = 0;
        tap_before = tap;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        check_eq({"R8 done seen ", tag}, int'(done), 1);
        if (sweep) begin
            model(m, stk, stkf, ctr, e, nr, nt);
            check_eq({"R7 R9 err ", tag}, int'(err), int'(e));
            check_eq({"R3 update requests ", tag}, rises, nr);
            check_eq({"R2 tests ", tag}, tests, nt);
            if (!(e && !stkf)) check_eq({"R5 R6 tap ", tag}, int'(tap), ctr);
            if (stk >= 0) check_eq({"R4 timeout length ", tag}, max_len, 16);
        end else begin
            check_eq({"R1 tap unchanged ", tag}, int'(tap), int'(tap_before));
            check_eq({"R1 no requests ", tag}, rises + tests, 0);
            check_eq({"R1 err low ", tag}, int'(err), 0);
            check_eq({"R1 done latency ", tag}, cyc, 0);
        end
        @(negedge clk);
        check_eq({"R8 done one cycle ", tag}, int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("reset tap", int'(tap), 0);
        check_eq("reset outputs", int'({upd_req, test_req, done, err}), 0);

        run_sweep(win(10, 20), -1, 1'b0, 3'd3, "single window");
        run_sweep(win(3, 7) | win(20, 24), -1, 1'b0, 3'd5, "R5 tie earliest");
        run_sweep('0, -1, 1'b0, 3'd3, "R7 none pass");
        repeat (20) @(negedge clk);
        check_eq("R8 err held", int'(err), 1);
        run_sweep(win(0, 5), -1, 1'b0, 3'd0, "R1 mode 0 after err");
        run_sweep('1, -1, 1'b0, 3'd3, "all pass");
        run_sweep(win(39, 39), -1, 1'b0, 3'd5, "top tap only");
        run_sweep(win(10, 11), -1, 1'b0, 3'd3, "R6 pair");
        run_sweep(win(5, 14), 9, 1'b0, 3'd3, "R4 stuck splits");
        run_sweep(win(2, 30), -1, 1'b1, 3'd5, "R9 final timeout");
        run_sweep(win(2, 30), -1, 1'b0, 3'd7, "R1 mode 7");
        for (int k = 0; k < 8; k++) begin
            bit [39:0] rm;
            int st;
            for (int i = 0; i < 40; i++) rm[i] = (($urandom % 4) != 0);
            st = (($urandom % 3) == 0) ? int'($urandom % 40) : -1;
            run_sweep(rm, st, 1'b0, (k % 2 == 0) ? 3'd3 : 3'd5, $sformatf("random %0d", k));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule